// File: doc/BRIEF.md
# Timed Clock Pattern Fragment Player

This block drives the clock and control lines of an image sensor readout from stored pattern words. Every word sets the levels of the vertical-transfer phases, the horizontal-transfer phases, the output-node reset gate, the summing gate and the two control lines of a dual-slope integrator. Each word also holds a dwell count in system clock cycles. Because every word carries its own dwell, the host sets vertical shift rate, horizontal shift rate and frame rate through data alone. For example, at 200 MHz a 200 ns horizontal shift is a few words whose dwells add up to 40 cycles.

A run is started by a fragment index and a repeat count. The index picks a start address from a small table. From that address the player steps through words in rising address order, wrapping at the top of memory, until it reaches a word whose end flag is set. It then goes back to the start address until the requested number of passes is complete. This looping gives the long, regular sequences needed for frame transfer and for on-chip binning. When the last pass finishes, the player pulses done and leaves the last levels on the pins.

Pattern memory and the start table are both loaded through one host write port.

Top module: `seqfrag_player`

## Requirements
- R1: While reset is active, and afterwards until the first start, every clock and control output, busy and done are 0.
- R2: A start pulse taken while busy is low makes the first word of the selected fragment appear on the outputs in the next cycle, with busy high.
- R3: A word whose dwell field holds N is kept on the outputs for exactly N cycles. A dwell of 0 lasts one cycle.
- R4: Words play in rising address order from the fragment's start address through the first word whose end flag is set.
- R5: The fragment plays as many passes as the repeat count asks. A count of 0 plays one pass.
- R6: In the cycle after the last dwell cycle of the final pass, done is high for exactly one cycle and busy is low. The outputs keep the last word's levels until the next start.
- R7: A start pulse taken while busy is high has no effect on the running sequence.
- R8: A write with wr_tab=1 stores wr_data[AW-1:0] as the start address of fragment wr_addr. A write with wr_tab=0 stores wr_data as the pattern word at address wr_addr.
- R9: Stepping past the highest memory address continues at address 0.
- R10: Word layout, from bit 0 upwards: the dwell count (HOLD_W bits), the vertical phases (PAR_N bits), the horizontal phases (SER_N bits), reset gate, summing gate, integrate-signal, integrate-reference, and the end flag as the top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_tab | input | 1 | 1: write the start table, 0: write pattern memory |
| wr_addr | input | AW | Memory address or fragment index |
| wr_data | input | WORD_W | Pattern word or start address |
| start | input | 1 | Begin a run (taken only while idle) |
| start_frag | input | FW | Fragment index for the run |
| start_reps | input | REP_W | Number of passes (0 means one) |
| par_ph | output | PAR_N | Vertical transfer phase levels |
| ser_ph | output | SER_N | Horizontal transfer phase levels |
| reset_gate | output | 1 | Output node reset gate level |
| sum_gate | output | 1 | Summing gate level |
| integ_sig | output | 1 | Integrator signal-window control |
| integ_ref | output | 1 | Integrator reference-window control |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The bench uses the default build: 32 words of memory, 4 fragments, 12-bit dwell and 8-bit repeat counts, and three phases per transfer direction. This keeps memory small enough that a fragment placed at the last two addresses runs into the wrap-around, and into the first fragment, within a short run. It also allows one fragment to start in the middle of another. Dwells of zero, one and several cycles, together with repeat counts of 0, 1, 2 and 3, cover every branch of the dwell and loop counters at several points in a pass.

// File: rtl/seqfrag_pkg.sv
package seqfrag_pkg;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/seqfrag_hold.sv
module seqfrag_hold #(
  parameter int HOLD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HOLD_W-1:0] load_val,
  output logic              last
);

  logic [HOLD_W-1:0] cnt_q;
  logic [HOLD_W-1:0] cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = (load_val == '0) ? HOLD_W'(1) : load_val;
    end else if (cnt_q > HOLD_W'(1)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - HOLD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == HOLD_W'(1));

endmodule

// File: rtl/seqfrag_store.sv
module seqfrag_store #(
  parameter int DEPTH  = 32,
  parameter int FRAG_N = 4,
  parameter int WORD_W = 23,
  parameter int AW     = 5,
  parameter int FW     = 2
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_tab,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_word,
  input  logic [FW-1:0]     tab_idx,
  output logic [AW-1:0]     tab_addr
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     tab [FRAG_N];
  logic              mem_we;
  logic              tab_we;

  assign mem_we = wr_en && !wr_tab;
  assign tab_we = wr_en && wr_tab && ({1'b0, wr_addr} < (AW+1)'(FRAG_N));

  always_ff @(posedge clk) begin
    if (mem_we) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (tab_we) begin
      tab[wr_addr[FW-1:0]] <= wr_data[AW-1:0];
    end
  end

  assign rd_word  = mem[rd_addr];
  assign tab_addr = tab[tab_idx];

endmodule

// File: rtl/seqfrag_outreg.sv
module seqfrag_outreg #(
  parameter int LVL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LVL_W-1:0] lvl_d,
  input  logic             end_d,
  output logic [LVL_W-1:0] lvl_q,
  output logic             end_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      end_q <= 1'b0;
    end else if (load) begin
      lvl_q <= lvl_d;
      end_q <= end_d;
    end
  end

endmodule

// File: rtl/seqfrag_ctrl.sv
module seqfrag_ctrl
  import seqfrag_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    tab_addr,
  input  logic [REP_W-1:0] reps,
  input  logic             hold_last,
  input  logic             cur_end,
  output logic             load,
  output logic [AW-1:0]    fetch_addr,
  output logic             busy,
  output logic             done
);

  localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);

  seq_state_e       state_q, state_d;
  logic [AW-1:0]    pc_q, pc_d;
  logic [AW-1:0]    base_q, base_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic             done_q, done_d;
  logic [AW-1:0]    pc_inc;

  assign pc_inc = (pc_q == TOP_ADDR) ? '0 : pc_q + AW'(1);

  always_comb begin
    state_d    = state_q;
    pc_d       = pc_q;
    base_d     = base_q;
    rep_d      = rep_q;
    done_d     = 1'b0;
    load       = 1'b0;
    fetch_addr = pc_inc;
    unique case (state_q)
      SQ_IDLE: begin
        if (start) begin
          load       = 1'b1;
          fetch_addr = tab_addr;
          pc_d       = tab_addr;
          base_d     = tab_addr;
          rep_d      = (reps == '0) ? REP_W'(1) : reps;
          state_d    = SQ_RUN;
        end
      end
      SQ_RUN: begin
        if (hold_last) begin
          if (cur_end) begin
            if (rep_q == REP_W'(1)) begin
              state_d = SQ_IDLE;
              done_d  = 1'b1;
            end else begin
              load       = 1'b1;
              fetch_addr = base_q;
              pc_d       = base_q;
              rep_d      = rep_q - REP_W'(1);
            end
          end else begin
            load       = 1'b1;
            fetch_addr = pc_inc;
            pc_d       = pc_inc;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      pc_q    <= '0;
      base_q  <= '0;
      rep_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      base_q  <= base_d;
      rep_q   <= rep_d;
      done_q  <= done_d;
    end
  end

  assign busy = (state_q == SQ_RUN);
  assign done = done_q;

endmodule

// File: rtl/seqfrag_player.sv
module seqfrag_player #(
  parameter int DEPTH  = 32,
  parameter int FRAG_N = 4,
  parameter int HOLD_W = 12,
  parameter int REP_W  = 8,
  parameter int PAR_N  = 3,
  parameter int SER_N  = 3,
  localparam int AW     = $clog2(DEPTH),
  localparam int FW     = (FRAG_N > 1) ? $clog2(FRAG_N) : 1,
  localparam int LVL_W  = PAR_N + SER_N + 4,
  localparam int WORD_W = HOLD_W + LVL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_tab,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              start,
  input  logic [FW-1:0]     start_frag,
  input  logic [REP_W-1:0]  start_reps,
  output logic [PAR_N-1:0]  par_ph,
  output logic [SER_N-1:0]  ser_ph,
  output logic              reset_gate,
  output logic              sum_gate,
  output logic              integ_sig,
  output logic              integ_ref,
  output logic              busy,
  output logic              done
);

  localparam int SER_LO = PAR_N;
  localparam int CTL_LO = PAR_N + SER_N;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [AW-1:0]     fetch_addr;
  logic [WORD_W-1:0] fetch_word;
  logic [AW-1:0]     tab_addr;
  logic              load;
  logic              hold_last;
  logic [LVL_W-1:0]  lvl_q;
  logic              end_q;

  // asynchronous assertion, release aligned to the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  seqfrag_store #(
    .DEPTH (DEPTH),
    .FRAG_N(FRAG_N),
    .WORD_W(WORD_W),
    .AW    (AW),
    .FW    (FW)
  ) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_tab  (wr_tab),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (fetch_addr),
    .rd_word (fetch_word),
    .tab_idx (start_frag),
    .tab_addr(tab_addr)
  );

  seqfrag_ctrl #(
    .DEPTH(DEPTH),
    .AW   (AW),
    .REP_W(REP_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .tab_addr  (tab_addr),
    .reps      (start_reps),
    .hold_last (hold_last),
    .cur_end   (end_q),
    .load      (load),
    .fetch_addr(fetch_addr),
    .busy      (busy),
    .done      (done)
  );

  seqfrag_hold #(
    .HOLD_W(HOLD_W)
  ) u_hold (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (load),
    .load_val(fetch_word[HOLD_W-1:0]),
    .last    (hold_last)
  );

  seqfrag_outreg #(
    .LVL_W(LVL_W)
  ) u_out (
    .clk  (clk),
    .rst_n(rst_int_n),
    .load (load),
    .lvl_d(fetch_word[HOLD_W +: LVL_W]),
    .end_d(fetch_word[WORD_W-1]),
    .lvl_q(lvl_q),
    .end_q(end_q)
  );

  assign par_ph     = lvl_q[PAR_N-1:0];
  assign ser_ph     = lvl_q[SER_LO +: SER_N];
  assign reset_gate = lvl_q[CTL_LO];
  assign sum_gate   = lvl_q[CTL_LO + 1];
  assign integ_sig  = lvl_q[CTL_LO + 2];
  assign integ_ref  = lvl_q[CTL_LO + 3];

endmodule

// File: rtl/seqfrag_player_chk.sv
module seqfrag_player_chk #(
  parameter int PIN_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [PIN_W-1:0] pins
);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R6
  idle_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(pins));

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  // R2
  start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && start && $past(rst_n)) |=> busy);

endmodule

bind seqfrag_player seqfrag_player_chk #(
  .PIN_W(PAR_N + SER_N + 4)
) u_chk (
  .clk  (clk),
  .rst_n(rst_int_n),
  .start(start),
  .busy (busy),
  .done (done),
  .pins ({integ_ref, integ_sig, sum_gate, reset_gate, ser_ph, par_ph})
);

// File: tb/seqfrag_player_bench.sv
module seqfrag_player_bench;

  localparam int DEPTH  = 32;
  localparam int FRAG_N = 4;
  localparam int HOLD_W = 12;
  localparam int REP_W  = 8;
  localparam int LV     = 10;
  localparam int WW     = HOLD_W + LV + 1;
  localparam int AW     = 5;
  localparam int FW     = 2;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic          wr_tab;
  logic [AW-1:0] wr_addr;
  logic [WW-1:0] wr_data;
  logic          start;
  logic [FW-1:0] start_frag;
  logic [REP_W-1:0] start_reps;
  logic [2:0]    par_ph;
  logic [2:0]    ser_ph;
  logic          reset_gate, sum_gate, integ_sig, integ_ref;
  logic          busy, done;
  logic [LV-1:0] got;

  typedef struct {
    logic [LV-1:0] lv;
    logic          busy;
    logic          done;
    string         req;
  } exp_t;

  exp_t          q[$];
  exp_t          mx;
  logic [WW-1:0] bm [DEPTH];
  logic [AW-1:0] bt [FRAG_N];
  int            total;
  int            bad;
  bit            finished;

  seqfrag_player u_seqfrag_player (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_tab    (wr_tab),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .start     (start),
    .start_frag(start_frag),
    .start_reps(start_reps),
    .par_ph    (par_ph),
    .ser_ph    (ser_ph),
    .reset_gate(reset_gate),
    .sum_gate  (sum_gate),
    .integ_sig (integ_sig),
    .integ_ref (integ_ref),
    .busy      (busy),
    .done      (done)
  );

  assign got = {integ_ref, integ_sig, sum_gate, reset_gate, ser_ph, par_ph};

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // R10 word layout: {end, iref, isig, sum, rst, ser[2:0], par[2:0], hold}
  function automatic logic [WW-1:0] mk(bit e, logic [LV-1:0] lv, int h);
    return {e, lv, HOLD_W'(h)};
  endfunction

  task automatic put_word(int a, logic [WW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_tab = 1'b0; wr_addr = AW'(a); wr_data = d;
    bm[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R8 start table write
  task automatic put_tab(int f, int a);
    @(negedge clk);
    wr_en = 1'b1; wr_tab = 1'b1; wr_addr = AW'(f); wr_data = WW'(a);
    bt[f] = AW'(a);
    @(negedge clk);
    wr_en = 1'b0; wr_tab = 1'b0;
  endtask

  task automatic push(logic [LV-1:0] lv, logic b, logic d, string req);
    exp_t it;
    it.lv = lv; it.busy = b; it.done = d; it.req = req;
    q.push_back(it);
  endtask

  task automatic play(int f, int reps, string tag, int poke);
    int a;
    int r;
    int h;
    bit e;
    bit first;
    logic [LV-1:0] lastlv;
    @(negedge clk);
    start = 1'b1; start_frag = FW'(f); start_reps = REP_W'(reps);
    r = (reps == 0) ? 1 : reps;
    first = 1'b1;
    lastlv = '0;
    for (int k = 0; k < r; k++) begin
      a = int'(bt[f]);
      e = 1'b0;
      for (int g = 0; g < 2 * DEPTH && !e; g++) begin
        h = int'(bm[a][HOLD_W-1:0]);
        if (h == 0) h = 1;
        lastlv = bm[a][HOLD_W +: LV];
        e = bm[a][WW-1];
        for (int c = 0; c < h; c++) begin
          push(lastlv, 1'b1, 1'b0, first ? "R2" : tag);
          first = 1'b0;
        end
        a = (a + 1) % DEPTH;
      end
    end
    push(lastlv, 1'b0, 1'b1, "R6");
    push(lastlv, 1'b0, 1'b0, "R6");
    @(negedge clk);
    start = 1'b0;
    if (poke > 0) begin
      repeat (poke - 1) @(negedge clk);
      start = 1'b1; start_frag = FW'((f + 1) % FRAG_N); start_reps = 8'd3;
      @(negedge clk);
      start = 1'b0;
    end
    while (q.size() > 0) @(negedge clk);
  endtask

  // monitor: compares one expected item per cycle while the queue holds items
  always begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      mx = q.pop_front();
      total++;
      if (got !== mx.lv || busy !== mx.busy || done !== mx.done) begin
        bad++;
        $display("FAIL %s: pins=%h busy=%b done=%b expected pins=%h busy=%b done=%b",
                 mx.req, got, busy, done, mx.lv, mx.busy, mx.done);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; finished = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_tab = 1'b0; wr_addr = '0; wr_data = '0;
    start = 1'b0; start_frag = '0; start_reps = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 idle state after reset
    total++;
    if (got !== '0 || busy !== 1'b0 || done !== 1'b0) begin
      bad++;
      $display("FAIL R1: pins=%h busy=%b done=%b expected pins=0 busy=0 done=0",
               got, busy, done);
    end

    // fragment 0 at 0..2, includes a zero dwell (R3)
    put_word(0,  mk(1'b0, 10'h001, 2));
    put_word(1,  mk(1'b0, 10'h002, 0));
    put_word(2,  mk(1'b1, 10'h3C4, 3));
    // fragment 1 at 8..11, a pixel-like pattern
    put_word(8,  mk(1'b0, 10'h048, 4));
    put_word(9,  mk(1'b0, 10'h090, 1));
    put_word(10, mk(1'b0, 10'h120, 5));
    put_word(11, mk(1'b1, 10'h208, 2));
    // fragment 2 at 30..31 runs over the top into 0..2 (R9)
    put_word(30, mk(1'b0, 10'h155, 1));
    put_word(31, mk(1'b0, 10'h2AA, 2));
    put_tab(0, 0);
    put_tab(1, 8);
    put_tab(2, 30);
    put_tab(3, 9);

    play(0, 1, "R3", 0);
    play(1, 1, "R4", 0);
    play(3, 2, "R8", 0);
    play(1, 3, "R5", 0);
    play(0, 0, "R5", 0);
    play(2, 1, "R9", 0);
    play(1, 1, "R7", 4);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule